// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

This block moves an operand one or two bit positions to the left or right. It works at byte, word or long width and returns the moved value together with the four condition flags: negative, zero, overflow and carry. Eight movement modes are available. Two are logical shifts and two are arithmetic shifts. Two are plain rotates, where the bit that leaves one end re-enters at the other. Two rotate through the carry flag, so that the carry acts as an extra bit of the operand.

A datapath presents one operation per clock with `in_valid`. The answer appears on the registered outputs one clock later, with `out_valid` high. The outputs keep their value until the next accepted operation. A two-position operation behaves as two one-position operations chained inside one cycle. The carry produced by the first step feeds the second step.

Top module: `shr_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `result` and all four flags are cleared to zero.
- R2: An operation accepted with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. When `in_valid` is low, `out_valid` drops and `result` and the flags hold their values.
- R3: `two_step` = 0 moves the operand by one position and `two_step` = 1 moves it by two. The two-position result and carry equal two one-position operations applied in sequence, with the carry out of the first operation used as the carry in of the second.
- R4: Logical left (`op` = 000) enters zeros at bit 0. C takes the last bit that left the top of the selected width. V is 0.
- R5: Logical right (`op` = 001) enters zeros at the top of the selected width. C takes the last bit that left bit 0. V is 0.
- R6: Arithmetic left (`op` = 010) moves the bits like logical left, and C takes the last bit that left the top. V is 1 when any bit that left the top, or the final sign bit, differs from the original sign bit. Otherwise V is 0.
- R7: Arithmetic right (`op` = 011) copies the original sign bit into every vacated top position. C takes the last bit that left bit 0. V is 0.
- R8: Plain rotate left (`op` = 100) and plain rotate right (`op` = 101) move the bit that leaves one end into the other end. C equals the last such bit. V is 0.
- R9: Rotate left through carry (`op` = 110) moves the incoming C into bit 0, and C receives the old top bit. Rotate right through carry (`op` = 111) moves the incoming C into the top bit, and C receives the old bit 0. V is 0 for both.
- R10: N equals the top bit of `result` at the selected width. Z is 1 exactly when `result` at that width is zero.
- R11: `size` = 00 selects 8 bits, 01 selects 16 bits and 10 selects 32 bits; the code 11 acts as 32 bits. Operand bits above the selected width have no effect, and `result` is zero above the selected width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 32 | Value to move, right-aligned |
| size | input | 2 | Width select: 00 byte, 01 word, 10 long |
| op | input | 3 | Movement mode, encoded as in R4 to R9 |
| two_step | input | 1 | 0 moves by one position, 1 moves by two |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registers hold a fresh answer |
| result | output | 32 | Moved value, zero above the selected width |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach is the arithmetic-left overflow of a two-position move. In that case, the first step keeps the sign and the second step brings in a differing bit. The case has to occur at each of the three widths, with unrelated data above the width so that the wrong sign position would be visible. The stimulus includes operands whose bit two below the top differs from the sign at byte, word and long width. Each such operand is run through every mode, width, count and carry value, alongside pseudo-random operands. A second reference chains two single-position answers, so that R3 is checked independently of the two-position model.

// File: rtl/shr_pkg.sv
// Shared constants and helpers for the shift and rotate unit.
// Assumes operands are right-aligned in a 32-bit field.
package shr_pkg;

    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W);

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_LONG = 2'b10;

    // Bit 0 of the mode gives the direction: 0 left, 1 right.
    localparam logic [2:0] OP_SHLL  = 3'b000;
    localparam logic [2:0] OP_SHLR  = 3'b001;
    localparam logic [2:0] OP_SHAL  = 3'b010;
    localparam logic [2:0] OP_SHAR  = 3'b011;
    localparam logic [2:0] OP_ROTL  = 3'b100;
    localparam logic [2:0] OP_ROTR  = 3'b101;
    localparam logic [2:0] OP_ROTXL = 3'b110;
    localparam logic [2:0] OP_ROTXR = 3'b111;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Position of the sign bit for a width code.
    function automatic logic [POS_W-1:0] top_pos(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: top_pos = POS_W'(7);
            SZ_WORD: top_pos = POS_W'(15);
            default: top_pos = POS_W'(DATA_W - 1);
        endcase
    endfunction

    // Ones over the active width for a width code.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: lane_mask = DATA_W'(32'h0000_00FF);
            SZ_WORD: lane_mask = DATA_W'(32'h0000_FFFF);
            default: lane_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/shr_step.sv
// One-position move of a right-aligned operand in any of the eight modes.
// Assumes din is already zero above the selected width; keeps dout that way.
module shr_step
    import shr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] din,
    input  logic [1:0]   sz,
    input  logic [2:0]   op,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout,
    output logic         vout
);

    localparam int PW = $clog2(W);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [PW-1:0] hi;
    logic [W-1:0]  mask;
    logic          msb;
    logic          lsb;
    logic          lfill;
    logic          rfill;
    logic [W-1:0]  moved_l;
    logic [W-1:0]  moved_r;

    // Width geometry for the current size code.
    always_comb begin
        hi   = PW'(top_pos(sz));
        mask = W'(lane_mask(sz));
        msb  = din[hi];
        lsb  = din[0];
    end

    // Bit entering at the low end on left moves.
    always_comb begin
        case (op)
            OP_ROTL:  lfill = msb;
            OP_ROTXL: lfill = cin;
            default:  lfill = 1'b0;
        endcase
    end

    // Bit entering at the top of the width on right moves.
    always_comb begin
        case (op)
            OP_SHAR:  rfill = msb;
            OP_ROTR:  rfill = lsb;
            OP_ROTXR: rfill = cin;
            default:  rfill = 1'b0;
        endcase
    end

    // Both candidate moves, then direction select with carry and overflow.
    always_comb begin
        moved_l = ((din << 1) & mask) | (lfill ? ONE : '0);
        moved_r = (din >> 1) | (rfill ? (ONE << hi) : '0);
        if (op[0]) begin
            dout = moved_r;
            cout = lsb;
        end else begin
            dout = moved_l;
            cout = msb;
        end
        vout = (op == OP_SHAL) && (moved_l[hi] != msb);
    end

endmodule

// File: rtl/shr_flags.sv
// Negative and zero flags of a right-aligned value at the selected width.
// Assumes value is zero above the selected width.
module shr_flags
    import shr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] value,
    input  logic [1:0]   sz,
    output logic         neg,
    output logic         zero
);

    localparam int PW = $clog2(W);

    // Sign pick and all-zero detect.
    always_comb begin
        neg  = value[PW'(top_pos(sz))];
        zero = (value == '0);
    end

endmodule

// File: rtl/shr_unit.sv
// Shift and rotate unit: masks the operand to its width, then applies
// one or two chained single-position steps and registers the result and flags.
// Assumes one operation per clock; the outputs hold between operations.
module shr_unit
    import shr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] operand,
    input  logic [1:0]  size,
    input  logic [2:0]  op,
    input  logic        two_step,
    input  logic        carry_in,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c
);

    localparam int W     = DATA_W;
    localparam int STEPS = 2;

    logic [W-1:0] stage_d [STEPS+1];
    logic         stage_c [STEPS+1];
    logic         stage_v [STEPS+1];
    logic         fl_n;
    logic         fl_z;
    ccr_t         ccr_q;

    assign stage_d[0] = operand & lane_mask(size);
    assign stage_c[0] = carry_in;
    assign stage_v[0] = 1'b0;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic [W-1:0] s_d;
        logic         s_c;
        logic         s_v;
        logic         en;

        assign en = (g == 0) || two_step;

        shr_step #(.W(W)) u_step (
            .din  (stage_d[g]),
            .sz   (size),
            .op   (op),
            .cin  (stage_c[g]),
            .dout (s_d),
            .cout (s_c),
            .vout (s_v)
        );

        assign stage_d[g+1] = en ? s_d : stage_d[g];
        assign stage_c[g+1] = en ? s_c : stage_c[g];
        assign stage_v[g+1] = stage_v[g] | (en & s_v);
    end

    shr_flags #(.W(W)) u_flags (
        .value (stage_d[STEPS]),
        .sz    (size),
        .neg   (fl_n),
        .zero  (fl_z)
    );

    // Output registers: capture on accepted operations, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ccr_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= stage_d[STEPS];
                ccr_q.n <= fl_n;
                ccr_q.z <= fl_z;
                ccr_q.v <= stage_v[STEPS];
                ccr_q.c <= stage_c[STEPS];
            end
        end
    end

    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;

endmodule

// File: rtl/shr_unit_chk.sv
// Temporal checks on the shift and rotate unit's ports, bound to every instance.
module shr_unit_chk
    import shr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] operand,
    input logic [1:0]  size,
    input logic [2:0]  op,
    input logic        two_step,
    input logic        carry_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R2
    AST_SHLL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHLL && size == SZ_LONG && !two_step)
        |=> (flag_c == $past(operand[31]) && !flag_v)); // R4
    AST_ROTL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROTL && size == SZ_BYTE && !two_step)
        |=> (result[0] == $past(operand[7]) && flag_c == $past(operand[7]))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_SHAL) |=> !flag_v); // R7
    AST_WORD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == SZ_WORD) |=> (flag_n == result[15])); // R10
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_z == (result == 32'h0))); // R10
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == SZ_BYTE) |=> (result[31:8] == 24'h0)); // R11

endmodule

bind shr_unit shr_unit_chk u_chk (.*);

// File: tb/tb_shr_unit.sv
`timescale 1ns/1ps
module tb_shr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = '0;
    logic [2:0]  op = '0;
    logic        two_step = 1'b0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .size(size), .op(op), .two_step(two_step), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h (op=%0d size=%0d two=%0b cin=%0b x=%08h)",
                     tag, what, act, exp, op, size, two_step, carry_in, operand);
        end
    endtask

    // Behavioural model: moves a bit at a time with wide integer arithmetic.
    task automatic ref_op(input logic [31:0] x, input logic [1:0] sz, input logic [2:0] md,
                          input int cnt, input logic cin,
                          output logic [31:0] r, output logic c, output logic v);
        int w;
        logic [63:0] a, m;
        logic top, bot, orig;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (64'h1 << w) - 64'h1;
        a = {32'h0, x} & m;
        orig = a[w-1];
        c = cin;
        v = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            top = a[w-1];
            bot = a[0];
            case (md)
                3'd0: begin a = (a << 1) & m; c = top; end
                3'd1: begin a = a >> 1; c = bot; end
                3'd2: begin a = (a << 1) & m; c = top;
                            v = v | (top != orig) | (a[w-1] != orig); end
                3'd3: begin a = (a >> 1) | ({63'h0, top} << (w-1)); c = bot; end
                3'd4: begin a = ((a << 1) & m) | {63'h0, top}; c = top; end
                3'd5: begin a = (a >> 1) | ({63'h0, bot} << (w-1)); c = bot; end
                3'd6: begin a = ((a << 1) & m) | {63'h0, c}; c = top; end
                default: begin a = (a >> 1) | ({63'h0, c} << (w-1)); c = bot; end
            endcase
        end
        r = a[31:0];
    endtask

    // Drive one operation, wait one clock, compare every output.
    task automatic apply(input logic [31:0] x, input logic [1:0] sz, input logic [2:0] md,
                         input logic two, input logic cin);
        logic [31:0] er, r1, r2;
        logic ec, ev, c1, v1, c2, v2, en, ez;
        string tg;
        int w;
        string tags [8] = '{"R4", "R5", "R6", "R7", "R8", "R8", "R9", "R9"};
        operand = x; size = sz; op = md; two_step = two; carry_in = cin; in_valid = 1'b1;
        ref_op(x, sz, md, two ? 2 : 1, cin, er, ec, ev);
        ref_op(x, sz, md, 1, cin, r1, c1, v1);
        ref_op(r1, sz, md, 1, c1, r2, c2, v2);
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        en = er[w-1];
        ez = (er == 32'h0);
        tg = tags[md];
        @(negedge clk);
        check(out_valid == 1'b1, "R2", "out_valid", {31'h0, out_valid}, 32'h1);
        check(result == er, tg, "result", result, er);
        check(flag_c == ec, tg, "carry", {31'h0, flag_c}, {31'h0, ec});
        check(flag_v == ev, (md == 3'd2) ? "R6" : tg, "overflow", {31'h0, flag_v}, {31'h0, ev});
        check(flag_n == en && flag_z == ez, "R10", "n,z",
              {30'h0, flag_n, flag_z}, {30'h0, en, ez});
        if (w < 32)
            check((result >> w) == 32'h0, "R11", "upper bits", result, er);
        if (two)
            check(result == r2 && flag_c == c2, "R3", "chained single steps",
                  {result[30:0], flag_c}, {r2[30:0], c2});
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] held;
        logic [31:0] pats [12] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h4000_0000,
                                   32'h2000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_00A0,
                                   32'h0000_C000, 32'h1234_5F20, 32'hA5A5_C3C3, 32'h5A5A_3C3C};
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check(out_valid == 1'b0 && result == 32'h0, "R1", "reset outputs",
              result, 32'h0);
        check({flag_n, flag_z, flag_v, flag_c} == 4'h0, "R1", "reset flags",
              {28'h0, flag_n, flag_z, flag_v, flag_c}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        lfsr = 32'hACE1_2468;
        for (int p = 0; p < 32; p++) begin
            logic [31:0] x;
            if (p < 12) x = pats[p];
            else begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                x = lfsr;
            end
            for (int m = 0; m < 8; m++)
                for (int s = 0; s < 3; s++)
                    for (int t = 0; t < 2; t++)
                        for (int ci = 0; ci < 2; ci++)
                            apply(x, 2'(s), 3'(m), t[0], ci[0]);
        end
        // R11: size code 11 acts as long
        apply(32'h8000_0001, 2'b11, 3'd4, 1'b0, 1'b0);
        // R2: idle cycles drop out_valid and hold the result
        held = result;
        in_valid = 1'b0;
        operand = 32'h1357_9BDF;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "idle out_valid", {31'h0, out_valid}, 32'h0);
        check(result == held, "R2", "idle hold", result, held);
        @(negedge clk);
        check(result == held, "R2", "idle hold second cycle", result, held);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule